// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block keeps the free-running timebase of an isochronous serial bus controller. It packs three cascaded counters into one 32-bit register. The low counter counts ticks of a 24.576 MHz enable, and one cycle is 3072 ticks. The middle counter counts cycles, 8000 to a second. The top counter counts seconds. Because two of the rollover points are not powers of two, the register is a mixed-radix value, not a plain binary count.

The register advances by one tick on each clock where `tick_en` is high. Software or a cycle master can preset all three fields in one step through the load port, and a load wins over a tick in the same clock. The block has two registered strobes. One marks the start of every counted cycle. The other marks each counted change of the register's top bit, which happens every 64 seconds. The block also gives the register value as a single linear tick count, worked out combinationally from the current register.

The block has no streaming data path, so all of its pins are plain control and status signals, and it has no back-pressure.

Top module: `bus_cycle_timer`

## Requirements
- R1: After reset, `timer_value`, `linear_ticks`, `cycle_start` and `sec64_pulse` are all zero.
- R2: The offset field is `timer_value[11:0]`. It increases by one at each clock edge where `tick_en` is high and `load_en` is low. When both inputs are low, the whole register keeps its value.
- R3: A counted tick at offset 3071 sets the offset to 0 and adds one to the cycle field, which is `timer_value[24:12]`.
- R4: A counted tick at offset 3071 and cycle 7999 sets both fields to 0 and adds one to the seconds field, which is `timer_value[31:25]`.
- R5: The seconds field wraps from 127 to 0, so the whole register goes from its maximum legal value to zero.
- R6: When `load_en` is high, the register takes `load_value` at the next edge, whatever `tick_en` is. A load raises neither strobe, even when it changes bit 31 or sets the offset to zero.
- R7: `cycle_start` is high for exactly the one clock that follows an edge where a counted tick wrapped the offset to zero. In that clock the offset reads 0.
- R8: `sec64_pulse` is high for exactly the one clock that follows an edge where counting changed bit 31. This happens when the seconds go from 63 to 64 and from 127 to 0. When bit 31 reads 0 during the pulse, the seconds have made a full 128-second wrap.
- R9: `linear_ticks` equals offset + 3072 × cycle + 24,576,000 × seconds, taken modulo 2^32. It follows the register in the same clock, with no extra latency.
- R10: A loaded offset of 3072 or more counts as a final offset, so the next counted tick sets it to 0 and carries into the cycle field. In the same way, a loaded cycle value of 8000 or more wraps to 0 and carries into the seconds field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advance the timer by one 24.576 MHz tick |
| load_en | input | 1 | Preset the register from `load_value` (wins over `tick_en`) |
| load_value | input | 32 | Value to preset: seconds, cycle and offset fields |
| timer_value | output | 32 | Current register: {seconds[6:0], cycle[12:0], offset[11:0]} |
| linear_ticks | output | 32 | Register value as a linear tick count |
| cycle_start | output | 1 | One-clock pulse after a counted offset wrap |
| sec64_pulse | output | 1 | One-clock pulse after a counted change of bit 31 |

## Verification
Two pairs of functions can act in the same clock.

The first pair is the two strobes. The bench loads offset 3071, cycle 7999 and seconds 63, and then sends one tick. That tick wraps all three counters and changes bit 31, so both strobes must rise together in the same clock. The bench repeats this from seconds 127 to cover the full wrap.

The second pair is a load and a tick arriving in the same clock. The bench asserts both inputs together. It then checks that the register holds exactly the loaded word and that neither strobe fires, including for a load that sets bit 31.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int OFFSET_W     = 12;
  localparam int COUNT_W      = 13;
  localparam int SEC_W        = 7;
  localparam int OFFSET_LIMIT = 3072;
  localparam int COUNT_LIMIT  = 8000;
  localparam int SEC_LIMIT    = 128;
  localparam int TIMER_W      = OFFSET_W + COUNT_W + SEC_W;
endpackage

// File: rtl/cyc_field_counter.sv
// One radix digit of the timer: counts when stepped, wraps at LIMIT-1 or above.
module cyc_field_counter #(
  parameter int WIDTH = 12,
  parameter int LIMIT = 3072
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  output logic [WIDTH-1:0] value,
  output logic             wrap
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(LIMIT - 1);

  logic at_last;
  assign at_last = (value >= LAST);
  assign wrap    = step && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= '0;
    else if (ld)     value <= ld_val;
    else if (wrap)   value <= '0;
    else if (step)   value <= value + WIDTH'(1);
  end

  AST_DIGIT_WRAPS_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && (value >= LAST)) |=> (value == '0)); // R10
  AST_DIGIT_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && (value < LAST)) |=> (value == $past(value) + WIDTH'(1))); // R2
endmodule

// File: rtl/cyc_tick_linear.sv
// Converts the mixed-radix fields into a single linear tick count.
module cyc_tick_linear #(
  parameter int OFFSET_W     = 12,
  parameter int COUNT_W      = 13,
  parameter int SEC_W        = 7,
  parameter int OFFSET_LIMIT = 3072,
  parameter int COUNT_LIMIT  = 8000,
  parameter int OUT_W        = 32
) (
  input  logic [OFFSET_W-1:0] offset,
  input  logic [COUNT_W-1:0]  count,
  input  logic [SEC_W-1:0]    secs,
  output logic [OUT_W-1:0]    ticks
);
  localparam logic [OUT_W-1:0] CYCLE_TICKS = OUT_W'(OFFSET_LIMIT);
  localparam logic [OUT_W-1:0] SEC_TICKS   = OUT_W'(64'(OFFSET_LIMIT) * 64'(COUNT_LIMIT));

  logic [OUT_W-1:0] part_cyc, part_sec;
  assign part_cyc = OUT_W'(count) * CYCLE_TICKS;
  assign part_sec = OUT_W'(secs) * SEC_TICKS;
  assign ticks    = OUT_W'(offset) + part_cyc + part_sec;
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import cyc_timer_pkg::*;
#(
  parameter int OFF_W   = OFFSET_W,
  parameter int CNT_W   = COUNT_W,
  parameter int SECS_W  = SEC_W,
  parameter int OFF_LIM = OFFSET_LIMIT,
  parameter int CNT_LIM = COUNT_LIMIT,
  parameter int SEC_LIM = SEC_LIMIT,
  localparam int TW     = OFF_W + CNT_W + SECS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load_en,
  input  logic [TW-1:0] load_value,
  output logic [TW-1:0] timer_value,
  output logic [TW-1:0] linear_ticks,
  output logic          cycle_start,
  output logic          sec64_pulse
);
  localparam int CNT_LSB = OFF_W;
  localparam int SEC_LSB = OFF_W + CNT_W;

  logic              tick;
  logic [OFF_W-1:0]  off_val;
  logic [CNT_W-1:0]  cnt_val;
  logic [SECS_W-1:0] sec_val;
  logic              off_wrap, cnt_wrap, sec_wrap;
  logic              top_flip;

  assign tick = tick_en && !load_en;

  cyc_field_counter #(.WIDTH(OFF_W), .LIMIT(OFF_LIM)) u_offset (
    .clk(clk), .rst_n(rst_n), .step(tick), .ld(load_en),
    .ld_val(load_value[CNT_LSB-1:0]), .value(off_val), .wrap(off_wrap));

  cyc_field_counter #(.WIDTH(CNT_W), .LIMIT(CNT_LIM)) u_cycle (
    .clk(clk), .rst_n(rst_n), .step(off_wrap), .ld(load_en),
    .ld_val(load_value[SEC_LSB-1:CNT_LSB]), .value(cnt_val), .wrap(cnt_wrap));

  cyc_field_counter #(.WIDTH(SECS_W), .LIMIT(SEC_LIM)) u_secs (
    .clk(clk), .rst_n(rst_n), .step(cnt_wrap), .ld(load_en),
    .ld_val(load_value[TW-1:SEC_LSB]), .value(sec_val), .wrap(sec_wrap));

  // The top bit of the seconds flips whenever all lower second bits are ones.
  assign top_flip = cnt_wrap && (&sec_val[SECS_W-2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle_start <= 1'b0;
      sec64_pulse <= 1'b0;
    end else begin
      cycle_start <= off_wrap;
      sec64_pulse <= top_flip;
    end
  end

  assign timer_value = {sec_val, cnt_val, off_val};

  cyc_tick_linear #(
    .OFFSET_W(OFF_W), .COUNT_W(CNT_W), .SEC_W(SECS_W),
    .OFFSET_LIMIT(OFF_LIM), .COUNT_LIMIT(CNT_LIM), .OUT_W(TW)
  ) u_linear (
    .offset(off_val), .count(cnt_val), .secs(sec_val), .ticks(linear_ticks));

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (timer_value == $past(load_value))); // R6
  AST_LOAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (!cycle_start && !sec64_pulse)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !tick_en) |=> $stable(timer_value)); // R2
  AST_CYCSTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (timer_value[OFF_W-1:0] == '0)); // R7
  AST_SEC64_TOGGLED: assert property (@(posedge clk) disable iff (!rst_n)
    sec64_pulse |-> (timer_value[TW-1] != $past(timer_value[TW-1]))); // R8
  AST_SEC_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !load_en) |=> (timer_value == '0)); // R5
endmodule

// File: tb/bus_cycle_timer_tb.sv
module bus_cycle_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_value = '0;
  logic [31:0] timer_value, linear_ticks;
  logic        cycle_start, sec64_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
    .load_value(load_value), .timer_value(timer_value),
    .linear_ticks(linear_ticks), .cycle_start(cycle_start),
    .sec64_pulse(sec64_pulse));

  function automatic logic [31:0] pack(int s, int c, int o);
    return {s[6:0], c[12:0], o[11:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; applies inputs for one edge and returns at the next negedge.
  task automatic cyc(bit t, bit l, logic [31:0] v);
    tick_en = t; load_en = l; load_value = v;
    @(negedge clk);
    tick_en = 1'b0; load_en = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 timer", timer_value, 32'd0);
    chk("R1 linear", linear_ticks, 32'd0);
    chk("R1 strobes", {30'd0, cycle_start, sec64_pulse}, 32'd0);
  endtask

  task automatic test_count();
    for (int i = 0; i < 5; i++) cyc(1, 0, '0);
    chk("R2 count5", timer_value, 32'd5);
    for (int i = 0; i < 3; i++) cyc(0, 0, '0);
    chk("R2 idle hold", timer_value, 32'd5);
    chk("R9 linear small", linear_ticks, 32'd5);
  endtask

  task automatic test_cycle_wrap();
    cyc(0, 1, pack(0, 0, 3070));
    cyc(1, 0, '0);
    chk("R2 to 3071", timer_value, pack(0, 0, 3071));
    chk("R7 no early strobe", {31'd0, cycle_start}, 32'd0);
    cyc(1, 0, '0);
    chk("R3 offset wrap", timer_value, pack(0, 1, 0));
    chk("R7 strobe", {31'd0, cycle_start}, 32'd1);
    cyc(0, 0, '0);
    chk("R7 one clock", {31'd0, cycle_start}, 32'd0);
  endtask

  task automatic test_second();
    cyc(0, 1, pack(5, 7999, 3071));
    cyc(1, 0, '0);
    chk("R4 second carry", timer_value, pack(6, 0, 0));
    chk("R9 linear secs", linear_ticks, 32'd147456000);
    chk("R8 no pulse at 6", {31'd0, sec64_pulse}, 32'd0);
  endtask

  task automatic test_sec64_coincide();
    cyc(0, 1, pack(63, 7999, 3071));
    cyc(1, 0, '0);
    chk("R8 value 64s", timer_value, 32'h8000_0000);
    chk("R8 sec64 with cycle_start", {30'd0, sec64_pulse, cycle_start}, 32'd3);
    cyc(0, 0, '0);
    chk("R8 one clock", {30'd0, sec64_pulse, cycle_start}, 32'd0);
  endtask

  task automatic test_wrap128();
    cyc(0, 1, pack(127, 7999, 3071));
    cyc(1, 0, '0);
    chk("R5 full wrap", timer_value, 32'd0);
    chk("R8 wrap pulse", {31'd0, sec64_pulse}, 32'd1);
    chk("R8 bit31 zero", {31'd0, timer_value[31]}, 32'd0);
  endtask

  task automatic test_load_priority();
    cyc(1, 1, 32'h1234_5678);
    chk("R6 load wins", timer_value, 32'h1234_5678);
    cyc(1, 1, 32'h8000_0000);
    chk("R6 load bit31", timer_value, 32'h8000_0000);
    chk("R6 no strobes", {30'd0, sec64_pulse, cycle_start}, 32'd0);
  endtask

  task automatic test_out_of_range();
    cyc(0, 1, pack(0, 2, 4000));
    cyc(1, 0, '0);
    chk("R10 offset over", timer_value, pack(0, 3, 0));
    chk("R10 cycle_start", {31'd0, cycle_start}, 32'd1);
    cyc(0, 1, pack(1, 8100, 3071));
    cyc(1, 0, '0);
    chk("R10 cycle over", timer_value, pack(2, 0, 0));
  endtask

  task automatic test_linear();
    cyc(0, 1, pack(2, 100, 7));
    chk("R9 linear mixed", linear_ticks, 32'd49459207);
    cyc(0, 1, pack(127, 7999, 3071));
    chk("R9 linear max", linear_ticks, 32'd3145727999);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_count();
    test_cycle_wrap();
    test_second();
    test_sec64_coincide();
    test_wrap128();
    test_load_priority();
    test_out_of_range();
    test_linear();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule